// File: doc/BRIEF.md
# Pixel Fetch Strobe Generator

This block runs on the dot clock of a video output path and produces clock-enable strobes. A serial strobe runs all the time and fires once every four dots. It gives downstream logic a steady time base that does not stop during blanking. A fetch strobe asks external video memory for the next 32-bit group of packed pixels. It fires only while the display is active. Its rate follows the selected pixel depth, so a deep pixel format fetches often and a shallow one fetches rarely. One cycle after each fetch, a load pulse tells the pixel unpacker to capture the returned group.

A phase counter tracks how many pixels of the current group have been shown. It advances only on active dots. It keeps its value through line and frame blanking. A group that is only partly used at the end of a line is therefore finished at the start of the next line, and no new fetch is issued for it. The pixel depth code is copied into the block only while a configuration lock input is low. This keeps the depth steady while the timing generator is running.

Top module: `pix_fetch_strobe`

## Requirements
- R1: While `rst_n` is low, `ser_stb`, `fetch_stb` and `load_pulse` are all low, and both the serial divider and the fetch phase are cleared.
- R2: After reset is released, `ser_stb` is high for exactly one cycle after every fourth rising edge of `clk`: after edges 4, 8, 12 and so on. This does not depend on `active`.
- R3: The depth code is decoded as 2'b00 = 1, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8 bits per pixel. With `active` held high, consecutive fetch pulses are 32, 16, 8 and 4 cycles apart for these codes.
- R4: `fetch_stb` is registered. It goes high for one cycle after an edge at which `active` is high and the fetch phase is zero. From reset, the first fetch therefore appears on the cycle after `active` is first sampled high.
- R5: While `active` is low, no fetch pulse is issued and the fetch phase holds its value. Pixels left in a group are used first when `active` returns. Example at 8 bpp: after 6 active dots and a blank, the next fetch appears after the 3rd active dot.
- R6: `bpp_code` is copied into the block on each edge at which `cfg_lock` is low. While `cfg_lock` is high, changes on `bpp_code` have no effect on the fetch interval.
- R7: `load_pulse` is high for exactly one cycle, on the cycle right after each `fetch_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| bpp_code | input | 2 | Pixel depth code: 00=1, 01=2, 10=4, 11=8 bits per pixel |
| cfg_lock | input | 1 | When high, the captured depth code is frozen |
| active | input | 1 | Active-display flag from the timing generator |
| ser_stb | output | 1 | Free-running strobe, one pulse every 4 dots |
| fetch_stb | output | 1 | Request for the next 32-bit pixel group |
| load_pulse | output | 1 | Unpacker load, one cycle after each fetch |

## Verification
The bench measures the spacing of fetch pulses for every depth code. A wrong decode or a wrap off by one shows up as a gap that is too long or too short. It stops the display after six active dots at 8 bpp and checks two things. No fetch may appear during the blank, and the next fetch must come after exactly three active dots. A design that reset the phase on blanking would fetch at once instead. It changes the depth code while the lock is high and expects the old interval to remain. It also checks that the serial strobe keeps its four-cycle rhythm while `active` toggles, which catches a divider gated by active display.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_4 = 2'b10,
    DEPTH_8 = 2'b11
  } depth_e;
endpackage

// File: rtl/pfs_ser_div.sv
module pfs_ser_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ser_stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(DIV - 1));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    stb_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign ser_stb = stb_q;

  // R2: serial strobe is a single-cycle pulse
  a_r2_ser_single: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |=> !ser_stb);
endmodule

// File: rtl/pfs_cfg.sv
module pfs_cfg
  import pfs_pkg::*;
#(
  parameter int GROUP_BITS = 32,
  parameter int PW = $clog2(GROUP_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bpp_code,
  input  logic          cfg_lock,
  output logic [PW-1:0] last_idx
);
  depth_e depth_q, depth_d;

  always_comb begin
    depth_d = cfg_lock ? depth_q : depth_e'(bpp_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= DEPTH_1;
    else        depth_q <= depth_d;
  end

  // pixels per group = GROUP_BITS / 2**code; last index is one less
  always_comb begin
    last_idx = PW'((GROUP_BITS >> int'(depth_q)) - 1);
  end

  // R6: captured depth frozen while locked
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(depth_q));
endmodule

// File: rtl/pfs_fetch_ctl.sv
module pfs_fetch_ctl #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [PW-1:0] last_idx,
  output logic          fetch_stb,
  output logic          load_pulse
);
  logic [PW-1:0] phase_q, phase_d;
  logic          fetch_q, fetch_d;
  logic          load_q, load_d;
  logic          wrap;

  always_comb begin
    wrap    = (phase_q >= last_idx);
    phase_d = phase_q;
    if (active) phase_d = wrap ? '0 : phase_q + 1'b1;
    fetch_d = active && (phase_q == '0);
    load_d  = fetch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      fetch_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fetch_q <= fetch_d;
      load_q  <= load_d;
    end
  end

  assign fetch_stb  = fetch_q;
  assign load_pulse = load_q;

  // R5: phase holds through blanking
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(phase_q));
  // R5: no fetch after a blank dot
  a_r5_no_blank_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !fetch_stb);
  // R4: fetch is a single-cycle pulse (groups hold at least 4 pixels)
  a_r4_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |=> !fetch_stb);
  // R7: load is a single-cycle pulse
  a_r7_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
endmodule

// File: rtl/pix_fetch_strobe.sv
module pix_fetch_strobe #(
  parameter int GROUP_BITS = 32,
  parameter int SER_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bpp_code,
  input  logic       cfg_lock,
  input  logic       active,
  output logic       ser_stb,
  output logic       fetch_stb,
  output logic       load_pulse
);
  localparam int PW = $clog2(GROUP_BITS);

  logic [PW-1:0] last_idx;

  pfs_ser_div #(.DIV(SER_DIV)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_stb (ser_stb)
  );

  pfs_cfg #(.GROUP_BITS(GROUP_BITS), .PW(PW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .bpp_code (bpp_code),
    .cfg_lock (cfg_lock),
    .last_idx (last_idx)
  );

  pfs_fetch_ctl #(.PW(PW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .last_idx   (last_idx),
    .fetch_stb  (fetch_stb),
    .load_pulse (load_pulse)
  );

  // R4: a fetch pulse always follows an active dot
  a_r4_fetch_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> $past(active));
endmodule

// File: tb/pix_fetch_strobe_tb.sv
module pix_fetch_strobe_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bpp_code;
  logic       cfg_lock;
  logic       active;
  logic       ser_stb, fetch_stb, load_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pix_fetch_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .bpp_code(bpp_code), .cfg_lock(cfg_lock),
    .active(active), .ser_stb(ser_stb), .fetch_stb(fetch_stb),
    .load_pulse(load_pulse)
  );

  task automatic check(input logic act, input logic exp, input string req,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; active = 1'b0; cfg_lock = 1'b0; bpp_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: outputs low while reset is held
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; active = 1'b1; cfg_lock = 1'b0; bpp_code = 2'b11;
    repeat (5) begin
      @(negedge clk);
      check(ser_stb, 1'b0, "R1", "ser_stb in reset");
      check(fetch_stb, 1'b0, "R1", "fetch_stb in reset");
      check(load_pulse, 1'b0, "R1", "load_pulse in reset");
    end
    rst_n = 1'b1; active = 1'b0;
  endtask

  // R2: serial strobe rhythm, independent of active
  task automatic t_ser();
    do_reset(2'b10);
    for (int n = 1; n <= 24; n++) begin
      active = (n % 3) == 0;
      @(negedge clk);
      check(ser_stb, (n % 4) == 0, "R2", $sformatf("ser_stb after edge %0d", n));
    end
    active = 1'b0;
  endtask

  // drive active from phase zero and check spacing of fetch pulses
  task automatic run_gap(input int ppg, input string req);
    active = 1'b1;
    @(negedge clk);
    check(fetch_stb, 1'b1, "R4", "first fetch after active");
    for (int k = 1; k <= ppg; k++) begin
      @(negedge clk);
      check(fetch_stb, k == ppg, req, $sformatf("fetch at gap step %0d of %0d", k, ppg));
      if (k == 1) check(load_pulse, 1'b1, "R7", "load after fetch");
      if (k == 2) check(load_pulse, 1'b0, "R7", "load single cycle");
    end
    active = 1'b0;
  endtask

  // R3: interval per depth code
  task automatic t_rate(input logic [1:0] code);
    do_reset(code);
    repeat (2) @(negedge clk);
    run_gap(32 >> code, "R3");
  endtask

  // R5: leftover pixels carry across blanking
  task automatic t_carry();
    do_reset(2'b11);
    repeat (2) @(negedge clk);
    active = 1'b1;
    for (int s = 1; s <= 6; s++) begin
      @(negedge clk);
      check(fetch_stb, (s == 1) || (s == 5), "R5", $sformatf("fetch active dot %0d", s));
    end
    active = 1'b0;
    for (int b = 1; b <= 10; b++) begin
      @(negedge clk);
      check(fetch_stb, 1'b0, "R5", $sformatf("fetch in blank %0d", b));
    end
    active = 1'b1;
    for (int s = 1; s <= 3; s++) begin
      @(negedge clk);
      check(fetch_stb, s == 3, "R5", $sformatf("resume dot %0d", s));
    end
    active = 1'b0;
  endtask

  // R6: code changes ignored while locked, taken while unlocked
  task automatic t_lock();
    do_reset(2'b11);
    repeat (2) @(negedge clk);
    cfg_lock = 1'b1; bpp_code = 2'b00;
    repeat (3) @(negedge clk);
    run_gap(4, "R6");
    do_reset(2'b11);
    repeat (2) @(negedge clk);
    bpp_code = 2'b00;
    repeat (2) @(negedge clk);
    cfg_lock = 1'b1; bpp_code = 2'b11;
    repeat (2) @(negedge clk);
    run_gap(32, "R6");
  endtask

  initial begin
    rst_n = 1'b0; active = 1'b0; cfg_lock = 1'b0; bpp_code = 2'b00;
    t_reset();
    t_ser();
    for (int c = 0; c < 4; c++) t_rate(c[1:0]);
    t_carry();
    t_lock();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule